// File: doc/BRIEF.md
# Programmable Logic Device Programming Session Sequencer

This block runs one complete programming session for a 22V10-class programmable logic device. On a start request it raises the programming-enable request and holds it for a settle dwell. It then pulses the bulk-erase output, walks the 44 columns of the product-term array in ascending order, writes the user signature column, and finally writes the twenty macrocell control fuses. It finishes by dropping programming enable for a minimum off time before it reports completion.

Column contents come from an external buffer through a read-request port with a fixed one-cycle read latency. Each column write is handed to a separate serial column engine through a start/done handshake. Erase leaves every fuse at 1, so any column whose effective contents are all ones is skipped. The signature column carries only 64 meaningful bits. The control fuses have no column address; they are sent with a side-band select that steers the engine to the dedicated control-fuse pin.

An abort input may end a session at any point while programming enable is high. The block then still honours the off dwell and ends in an error state. All dwell times are parameterised as system-clock cycle counts.

Top module: `pld_session_seq`

## Requirements
- R1: While reset is asserted and after its release, `pgm_en_o`, `erase_o`, `buf_rd_o`, `col_start_o`, `done_o` and `err_o` are all 0 until `start_i` is seen.
- R2: A start from idle, done or error raises `pgm_en_o` on the next cycle. `erase_o` rises exactly SETTLE_CYC cycles after `pgm_en_o` rose and stays high for exactly ERASE_CYC cycles. `pgm_en_o` stays high throughout, and until the last column step has finished.
- R3: After erase, the buffer is read with one-cycle `buf_rd_o` pulses at addresses 0 to 43 in ascending order, then address 44 (signature), then address CTL_BUF_ADDR (default 63, control fuses): 46 reads per complete session. Read data is taken from `buf_rdata_i` one cycle after the request.
- R4: A product-term column k is written with a `col_start_o` pulse carrying `col_addr_o` = k, `col_ctl_o` = 0 and `col_data_o` equal to the buffered word. No further buffer read or column start occurs until `col_done_i` has been seen.
- R5: A step whose effective 132-bit word is all ones produces no `col_start_o`, and the sequence moves on to the next read.
- R6: The signature column is written to engine address 0x2C. Bits 131..68 come from the buffer and bits 67..0 are forced to 1, so that only the 64 bits shifted out first are meaningful.
- R7: The control-fuse step drives `col_ctl_o` = 1 and `col_addr_o` = 0. `col_data_o[19:0]` holds buffer bits 19..0 and bits 131..20 are forced to 1.
- R8: After the final step, `pgm_en_o` falls, and `done_o` rises exactly OFF_CYC cycles later.
- R9: `abort_i` while `pgm_en_o` is high drops `pgm_en_o` on the next cycle, and `err_o` rises exactly OFF_CYC cycles after the fall. `abort_i` has no effect while `pgm_en_o` is low.
- R10: `done_o` and `err_o` are levels that are never high together and hold until the next `start_i`. The next session starts again from column 0.
- R11: `col_start_o` is a single-cycle pulse, and at most one of `erase_o`, `buf_rd_o` and `col_start_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a programming session |
| abort_i | input | 1 | End the session early through the off dwell |
| pgm_en_o | output | 1 | Programming-enable request to the high-voltage driver |
| erase_o | output | 1 | Bulk-erase pulse |
| buf_rd_o | output | 1 | Column buffer read request |
| buf_addr_o | output | AW | Column buffer read address |
| buf_rdata_i | input | DW | Buffer read data, valid one cycle after the request |
| col_start_o | output | 1 | Start one column write on the serial engine |
| col_addr_o | output | AW | Column address for the engine |
| col_ctl_o | output | 1 | Select the dedicated control-fuse pin instead of a column address |
| col_data_o | output | DW | Column word for the engine, shifted out MSB first |
| col_done_i | input | 1 | Engine finished the current write |
| done_o | output | 1 | Session completed |
| err_o | output | 1 | Session aborted |

## Verification
A wrong column index or select flag shows up on the very next buffer request or column start as a wrong address, a wrong `col_ctl_o` or misplaced masked bits. A wrong skip decision shows up as a missing or extra `col_start_o` within three cycles of the read. A dwell counter that is off by one moves the rising edge of `erase_o`, `done_o` or `err_o` by one cycle relative to the edge of `pgm_en_o`, and the bench measures that distance exactly. A lost abort flag shows up as `done_o` in place of `err_o` when the off dwell ends.

// File: rtl/pld_seq_pkg.sv
package pld_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE   = 4'd0,
    ST_SETTLE = 4'd1,
    ST_ERASE  = 4'd2,
    ST_FETCH  = 4'd3,
    ST_LOAD   = 4'd4,
    ST_ISSUE  = 4'd5,
    ST_BUSY   = 4'd6,
    ST_OFF    = 4'd7,
    ST_DONE   = 4'd8,
    ST_FAIL   = 4'd9
  } seq_state_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/pld_rst_sync.sv
module pld_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;

endmodule

// File: rtl/pld_dwell_timer.sv
module pld_dwell_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic [TW-1:0] lim_i,
  output logic          hit_o
);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;

  // The count reaches lim-1 after lim cycles in a state.
  assign hit_o = (cnt_q == lim_i - TW'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (!hit_o) cnt_d = cnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/pld_col_stager.sv
module pld_col_stager #(
  parameter int DW           = 132,
  parameter int AW           = 6,
  parameter int COLS         = 44,
  parameter int SIG_COL      = 44,
  parameter int SIG_BITS     = 64,
  parameter int CTL_BITS     = 20,
  parameter int CTL_BUF_ADDR = 63
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart_i,
  input  logic          step_i,
  input  logic          load_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] buf_addr_o,
  output logic [AW-1:0] col_addr_o,
  output logic          col_ctl_o,
  output logic [DW-1:0] data_o,
  output logic          skip_o,
  output logic          last_o
);

  localparam int STEPS   = COLS + 2;
  localparam int IW      = $clog2(STEPS);
  localparam int SIG_IDX = COLS;
  localparam int CTL_IDX = COLS + 1;
  localparam int SIG_LSB = DW - SIG_BITS;

  logic [IW-1:0] idx_q;
  logic [IW-1:0] idx_d;
  logic          is_sig;
  logic          is_ctl;
  logic [DW-1:0] data_q;
  logic [DW-1:0] data_d;

  assign is_sig = (idx_q == IW'(SIG_IDX));
  assign is_ctl = (idx_q == IW'(CTL_IDX));

  always_comb begin
    idx_d = idx_q;
    if (restart_i)   idx_d = '0;
    else if (step_i) idx_d = idx_q + IW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  // Per-bit masking: positions outside the meaningful field read as erased (1).
  for (genvar b = 0; b < DW; b++) begin : g_mask
    localparam bit KEEP_SIG = (b >= SIG_LSB);
    localparam bit KEEP_CTL = (b < CTL_BITS);
    always_comb begin
      if (is_ctl)      data_d[b] = KEEP_CTL ? rdata_i[b] : 1'b1;
      else if (is_sig) data_d[b] = KEEP_SIG ? rdata_i[b] : 1'b1;
      else             data_d[b] = rdata_i[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (load_i) data_q <= data_d;
  end

  always_comb begin
    if (is_ctl)      buf_addr_o = AW'(CTL_BUF_ADDR);
    else             buf_addr_o = AW'(idx_q);
    if (is_ctl)      col_addr_o = '0;
    else if (is_sig) col_addr_o = AW'(SIG_COL);
    else             col_addr_o = AW'(idx_q);
  end

  assign col_ctl_o = is_ctl;
  assign data_o    = data_q;
  assign skip_o    = &data_q;
  assign last_o    = is_ctl;

endmodule

// File: rtl/pld_seq_fsm.sv
module pld_seq_fsm
  import pld_seq_pkg::*;
#(
  parameter int TW         = 8,
  parameter int SETTLE_CYC = 100,
  parameter int ERASE_CYC  = 50,
  parameter int OFF_CYC    = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic          col_done_i,
  input  logic          hit_i,
  input  logic          skip_i,
  input  logic          last_i,
  output logic [TW-1:0] lim_o,
  output logic          tclr_o,
  output logic          pgm_en_o,
  output logic          erase_o,
  output logic          buf_rd_o,
  output logic          load_o,
  output logic          step_o,
  output logic          restart_o,
  output logic          col_start_o,
  output logic          done_o,
  output logic          err_o
);

  seq_state_e state_q;
  seq_state_e state_n;
  logic       aborted_q;
  logic       aborted_d;
  logic       idle_like;
  logic       live;
  logic       advance;

  assign idle_like = (state_q == ST_IDLE) || (state_q == ST_DONE) || (state_q == ST_FAIL);
  assign live      = (state_q == ST_SETTLE) || (state_q == ST_ERASE) || (state_q == ST_FETCH) ||
                     (state_q == ST_LOAD)   || (state_q == ST_ISSUE) || (state_q == ST_BUSY);

  // A column step is finished either by a skip or by the engine's done.
  assign advance = !abort_i && (((state_q == ST_ISSUE) && skip_i) ||
                                ((state_q == ST_BUSY) && col_done_i));

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_IDLE, ST_DONE, ST_FAIL: if (start_i) state_n = ST_SETTLE;
      ST_SETTLE: begin
        if (abort_i)    state_n = ST_OFF;
        else if (hit_i) state_n = ST_ERASE;
      end
      ST_ERASE: begin
        if (abort_i)    state_n = ST_OFF;
        else if (hit_i) state_n = ST_FETCH;
      end
      ST_FETCH: state_n = abort_i ? ST_OFF : ST_LOAD;
      ST_LOAD:  state_n = abort_i ? ST_OFF : ST_ISSUE;
      ST_ISSUE: begin
        if (abort_i)     state_n = ST_OFF;
        else if (skip_i) state_n = last_i ? ST_OFF : ST_FETCH;
        else             state_n = ST_BUSY;
      end
      ST_BUSY: begin
        if (abort_i)         state_n = ST_OFF;
        else if (col_done_i) state_n = last_i ? ST_OFF : ST_FETCH;
      end
      ST_OFF: if (hit_i) state_n = aborted_q ? ST_FAIL : ST_DONE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_comb begin
    aborted_d = aborted_q;
    if (restart_o)          aborted_d = 1'b0;
    else if (abort_i && live) aborted_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      aborted_q <= 1'b0;
    end else begin
      state_q   <= state_n;
      aborted_q <= aborted_d;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_SETTLE: lim_o = TW'(SETTLE_CYC);
      ST_ERASE:  lim_o = TW'(ERASE_CYC);
      ST_OFF:    lim_o = TW'(OFF_CYC);
      default:   lim_o = TW'(1);
    endcase
  end

  assign tclr_o      = (state_n != state_q);
  assign pgm_en_o    = live;
  assign erase_o     = (state_q == ST_ERASE);
  assign buf_rd_o    = (state_q == ST_FETCH);
  assign load_o      = (state_q == ST_LOAD);
  assign col_start_o = (state_q == ST_ISSUE) && !abort_i && !skip_i;
  assign step_o      = advance && !last_i;
  assign restart_o   = idle_like && start_i;
  assign done_o      = (state_q == ST_DONE);
  assign err_o       = (state_q == ST_FAIL);

endmodule

// File: rtl/pld_session_seq.sv
module pld_session_seq
  import pld_seq_pkg::*;
#(
  parameter int DW           = 132,
  parameter int AW           = 6,
  parameter int COLS         = 44,
  parameter int SIG_COL      = 44,
  parameter int SIG_BITS     = 64,
  parameter int CTL_BITS     = 20,
  parameter int CTL_BUF_ADDR = 63,
  parameter int SETTLE_CYC   = 2500000,
  parameter int ERASE_CYC    = 500000,
  parameter int OFF_CYC      = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          abort_i,
  output logic          pgm_en_o,
  output logic          erase_o,
  output logic          buf_rd_o,
  output logic [AW-1:0] buf_addr_o,
  input  logic [DW-1:0] buf_rdata_i,
  output logic          col_start_o,
  output logic [AW-1:0] col_addr_o,
  output logic          col_ctl_o,
  output logic [DW-1:0] col_data_o,
  input  logic          col_done_i,
  output logic          done_o,
  output logic          err_o
);

  localparam int unsigned MAXC = max3(SETTLE_CYC, ERASE_CYC, OFF_CYC);
  localparam int TW = $clog2(MAXC + 1);

  logic          rst_sync_n;
  logic [TW-1:0] lim;
  logic          tclr;
  logic          hit;
  logic          skip;
  logic          last;
  logic          load;
  logic          step;
  logic          restart;

  pld_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pld_dwell_timer #(.TW(TW)) u_timer (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr_i (tclr),
    .lim_i (lim),
    .hit_o (hit)
  );

  pld_col_stager #(
    .DW(DW), .AW(AW), .COLS(COLS), .SIG_COL(SIG_COL), .SIG_BITS(SIG_BITS),
    .CTL_BITS(CTL_BITS), .CTL_BUF_ADDR(CTL_BUF_ADDR)
  ) u_stager (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .restart_i  (restart),
    .step_i     (step),
    .load_i     (load),
    .rdata_i    (buf_rdata_i),
    .buf_addr_o (buf_addr_o),
    .col_addr_o (col_addr_o),
    .col_ctl_o  (col_ctl_o),
    .data_o     (col_data_o),
    .skip_o     (skip),
    .last_o     (last)
  );

  pld_seq_fsm #(
    .TW(TW), .SETTLE_CYC(SETTLE_CYC), .ERASE_CYC(ERASE_CYC), .OFF_CYC(OFF_CYC)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .start_i     (start_i),
    .abort_i     (abort_i),
    .col_done_i  (col_done_i),
    .hit_i       (hit),
    .skip_i      (skip),
    .last_i      (last),
    .lim_o       (lim),
    .tclr_o      (tclr),
    .pgm_en_o    (pgm_en_o),
    .erase_o     (erase_o),
    .buf_rd_o    (buf_rd_o),
    .load_o      (load),
    .step_o      (step),
    .restart_o   (restart),
    .col_start_o (col_start_o),
    .done_o      (done_o),
    .err_o       (err_o)
  );

endmodule

// File: rtl/pld_session_seq_chk.sv
module pld_session_seq_chk #(
  parameter int DW         = 132,
  parameter int AW         = 6,
  parameter int SIG_COL    = 44,
  parameter int SIG_BITS   = 64,
  parameter int CTL_BITS   = 20,
  parameter int SETTLE_CYC = 2500000,
  parameter int OFF_CYC    = 1000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          abort_i,
  input logic          pgm_en_o,
  input logic          erase_o,
  input logic          buf_rd_o,
  input logic          col_start_o,
  input logic [AW-1:0] col_addr_o,
  input logic          col_ctl_o,
  input logic [DW-1:0] col_data_o,
  input logic          done_o,
  input logic          err_o
);

  // Cycle counts of the current high and low stretches of programming enable.
  logic [31:0] hi_cnt;
  logic [31:0] lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else begin
      if (pgm_en_o) begin
        lo_cnt <= '0;
        if (hi_cnt != 32'hFFFF_FFFF) hi_cnt <= hi_cnt + 32'd1;
      end else begin
        hi_cnt <= '0;
        if (lo_cnt != 32'hFFFF_FFFF) lo_cnt <= lo_cnt + 32'd1;
      end
    end
  end

  p_settle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(erase_o) |-> (hi_cnt >= 32'(SETTLE_CYC)));

  p_en_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_o || buf_rd_o || col_start_o) |-> pgm_en_o);

  p_no_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    col_start_o |-> !(&col_data_o));

  p_sig_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (col_start_o && !col_ctl_o && (col_addr_o == AW'(SIG_COL)))
      |-> (&col_data_o[DW-SIG_BITS-1:0]));

  p_ctl_fmt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (col_start_o && col_ctl_o) |-> ((col_addr_o == '0) && (&col_data_o[DW-1:CTL_BITS])));

  p_off_dwell_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done_o) || $rose(err_o)) |-> (lo_cnt >= 32'(OFF_CYC)));

  p_abort_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_i && pgm_en_o) |=> !pgm_en_o);

  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));

  p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    col_start_o |=> !col_start_o);

  p_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({erase_o, buf_rd_o, col_start_o}));

endmodule

bind pld_session_seq pld_session_seq_chk #(
  .DW(DW), .AW(AW), .SIG_COL(SIG_COL), .SIG_BITS(SIG_BITS), .CTL_BITS(CTL_BITS),
  .SETTLE_CYC(SETTLE_CYC), .OFF_CYC(OFF_CYC)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .abort_i     (abort_i),
  .pgm_en_o    (pgm_en_o),
  .erase_o     (erase_o),
  .buf_rd_o    (buf_rd_o),
  .col_start_o (col_start_o),
  .col_addr_o  (col_addr_o),
  .col_ctl_o   (col_ctl_o),
  .col_data_o  (col_data_o),
  .done_o      (done_o),
  .err_o       (err_o)
);

// File: tb/pld_session_seq_tb_top.sv
module pld_session_seq_tb_top;

  localparam int DW     = 132;
  localparam int AW     = 6;
  localparam int SETTLE = 20;
  localparam int ERASE  = 5;
  localparam int OFF    = 10;
  localparam int NSTEP  = 46;

  logic          clk;
  logic          rst_n;
  logic          start_i;
  logic          abort_i;
  logic          pgm_en_o;
  logic          erase_o;
  logic          buf_rd_o;
  logic [AW-1:0] buf_addr_o;
  logic [DW-1:0] buf_rdata_i;
  logic          col_start_o;
  logic [AW-1:0] col_addr_o;
  logic          col_ctl_o;
  logic [DW-1:0] col_data_o;
  logic          col_done_i;
  logic          done_o;
  logic          err_o;

  pld_session_seq #(
    .SETTLE_CYC(SETTLE), .ERASE_CYC(ERASE), .OFF_CYC(OFF)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
    .pgm_en_o(pgm_en_o), .erase_o(erase_o), .buf_rd_o(buf_rd_o),
    .buf_addr_o(buf_addr_o), .buf_rdata_i(buf_rdata_i),
    .col_start_o(col_start_o), .col_addr_o(col_addr_o), .col_ctl_o(col_ctl_o),
    .col_data_o(col_data_o), .col_done_i(col_done_i), .done_o(done_o), .err_o(err_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int seed = 0;
  bit fin = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int s, input int a);
    logic [DW-1:0] v;
    if (((a + s) % 4) == 0) return '1;
    for (int i = 0; i < DW; i++) v[i] = (((i * 3 + a * 5 + s) % 7) < 4);
    return v;
  endfunction

  // Buffer model: one-cycle read latency.
  always @(posedge clk) begin
    if (buf_rd_o) buf_rdata_i <= pat(seed, int'(buf_addr_o));
  end

  // Column engine model: done pulse a few cycles after start.
  int eng_cnt = 0;
  bit eng_busy = 1'b0;
  initial col_done_i = 1'b0;
  always @(posedge clk) begin
    if (col_start_o) begin
      eng_busy   <= 1'b1;
      eng_cnt    <= (int'(col_addr_o) % 3) + 1;
      col_done_i <= 1'b0;
    end else if (eng_busy) begin
      if (eng_cnt == 0) begin
        col_done_i <= 1'b1;
        eng_busy   <= 1'b0;
      end else begin
        eng_cnt <= eng_cnt - 1;
      end
    end else begin
      col_done_i <= 1'b0;
    end
  end

  // Expected write list, built from the requirements.
  logic [DW-1:0] exp_data [0:NSTEP-1];
  int            exp_addr [0:NSTEP-1];
  bit            exp_ctl  [0:NSTEP-1];
  int n_w = 0;
  int rd_k = 0;
  int wr_k = 0;

  task automatic build_expect();
    logic [DW-1:0] w;
    n_w = 0;
    for (int k = 0; k < NSTEP; k++) begin
      if (k < 44) w = pat(seed, k);
      else if (k == 44) w = {pat(seed, 44)[DW-1:68], 68'h0 | {68{1'b1}}};
      else w = {{(DW-20){1'b1}}, pat(seed, 63)[19:0]};
      if (!(&w)) begin
        exp_data[n_w] = w;
        exp_addr[n_w] = (k == 45) ? 0 : k;
        exp_ctl[n_w]  = (k == 45);
        n_w++;
      end
    end
    rd_k = 0;
    wr_k = 0;
  endtask

  // Monitor, sampled on the falling edge.
  bit prev_en = 1'b0, prev_er = 1'b0, prev_dn = 1'b0, prev_ee = 1'b0;
  int t_en = 0, t_er = 0, t_off = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pgm_en_o && !prev_en) t_en = cyc;
      if (!pgm_en_o && prev_en) t_off = cyc;
      if (erase_o && !prev_er) begin
        chk(cyc - t_en == SETTLE, "R2 settle dwell", DW'(cyc - t_en), DW'(SETTLE));
        t_er = cyc;
      end
      if (!erase_o && prev_er) begin
        chk(cyc - t_er == ERASE, "R2 erase width", DW'(cyc - t_er), DW'(ERASE));
        chk(pgm_en_o, "R2 enable held after erase", DW'(pgm_en_o), DW'(1));
      end
      if (done_o && !prev_dn)
        chk(cyc - t_off == OFF, "R8 off dwell before done", DW'(cyc - t_off), DW'(OFF));
      if (err_o && !prev_ee)
        chk(cyc - t_off == OFF, "R9 off dwell before error", DW'(cyc - t_off), DW'(OFF));
      if (buf_rd_o) begin
        chk(int'(buf_addr_o) == ((rd_k < 45) ? rd_k : 63), "R3 read address order",
            DW'(buf_addr_o), DW'((rd_k < 45) ? rd_k : 63));
        chk(!eng_busy, "R4 read while engine busy", DW'(eng_busy), DW'(0));
        rd_k++;
      end
      if (col_start_o) begin
        chk(!eng_busy, "R4 start while engine busy", DW'(eng_busy), DW'(0));
        if (wr_k < n_w) begin
          chk(int'(col_addr_o) == exp_addr[wr_k], "R4 R5 R6 R7 column address",
              DW'(col_addr_o), DW'(exp_addr[wr_k]));
          chk(col_ctl_o == exp_ctl[wr_k], "R7 control select",
              DW'(col_ctl_o), DW'(exp_ctl[wr_k]));
          chk(col_data_o == exp_data[wr_k], "R4 R6 R7 column data",
              col_data_o, exp_data[wr_k]);
        end else begin
          chk(1'b0, "R5 extra column write", DW'(wr_k), DW'(n_w));
        end
        wr_k++;
      end
    end
    prev_en = pgm_en_o;
    prev_er = erase_o;
    prev_dn = done_o;
    prev_ee = err_o;
  end

  task automatic do_start(input int s);
    @(negedge clk);
    seed = s;
    build_expect();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(pgm_en_o, "R2 enable after start", DW'(pgm_en_o), DW'(1));
    chk(!done_o && !err_o, "R10 status cleared by start", DW'({done_o, err_o}), DW'(0));
  endtask

  task automatic wait_end();
    int n = 0;
    while (!done_o && !err_o && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic pulse_abort();
    @(negedge clk);
    abort_i = 1'b1;
    @(negedge clk);
    abort_i = 1'b0;
  endtask

  initial begin
    rst_n   = 1'b0;
    start_i = 1'b0;
    abort_i = 1'b0;
    repeat (3) @(negedge clk);
    chk({pgm_en_o, erase_o, buf_rd_o, col_start_o, done_o, err_o} == 6'b0,
        "R1 reset outputs", DW'({pgm_en_o, erase_o, buf_rd_o, col_start_o, done_o, err_o}), DW'(0));
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk({pgm_en_o, erase_o, buf_rd_o, col_start_o, done_o, err_o} == 6'b0,
        "R1 idle after release", DW'({pgm_en_o, erase_o, buf_rd_o, col_start_o, done_o, err_o}), DW'(0));

    // Session with the signature column all ones (skipped).
    do_start(0);
    wait_end();
    chk(done_o && !err_o, "R8 session ends in done", DW'({done_o, err_o}), DW'(2));
    chk(rd_k == NSTEP, "R3 read count", DW'(rd_k), DW'(NSTEP));
    chk(wr_k == n_w, "R5 write count with skips", DW'(wr_k), DW'(n_w));

    // Abort with enable low has no effect.
    pulse_abort();
    repeat (3) @(negedge clk);
    chk(done_o && !err_o && !pgm_en_o, "R9 abort ignored when idle",
        DW'({done_o, err_o, pgm_en_o}), DW'(4));
    chk(done_o, "R10 done held", DW'(done_o), DW'(1));

    // Restart from done; control word all ones (skipped), signature written.
    do_start(1);
    wait_end();
    chk(done_o && !err_o, "R10 second session done", DW'({done_o, err_o}), DW'(2));
    chk(rd_k == NSTEP, "R3 read count restart", DW'(rd_k), DW'(NSTEP));
    chk(wr_k == n_w, "R5 write count restart", DW'(wr_k), DW'(n_w));

    // Abort in the middle of the column walk.
    do_start(2);
    while (wr_k < 5) @(negedge clk);
    abort_i = 1'b1;
    @(negedge clk);
    abort_i = 1'b0;
    chk(!pgm_en_o, "R9 enable drops after abort", DW'(pgm_en_o), DW'(0));
    wait_end();
    chk(err_o && !done_o, "R9 abort ends in error", DW'({done_o, err_o}), DW'(1));
    repeat (4) @(negedge clk);
    chk(err_o && !done_o, "R10 error held", DW'({done_o, err_o}), DW'(1));

    // Abort during the settle dwell: no erase, error after off dwell.
    do_start(3);
    repeat (5) @(negedge clk);
    abort_i = 1'b1;
    @(negedge clk);
    abort_i = 1'b0;
    chk(!pgm_en_o, "R9 enable drops in settle", DW'(pgm_en_o), DW'(0));
    wait_end();
    chk(err_o, "R9 settle abort error", DW'(err_o), DW'(1));
    chk(rd_k == 0, "R9 no reads after settle abort", DW'(rd_k), DW'(0));

    // Recover from error with a full session.
    do_start(0);
    wait_end();
    chk(done_o && !err_o, "R10 start from error", DW'({done_o, err_o}), DW'(2));
    chk(wr_k == n_w, "R4 write count after error", DW'(wr_k), DW'(n_w));

    fin = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R8 actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule